// File: doc/BRIEF.md
# Watchdog Timer with Protected Configuration

This block is a watchdog. A free-running divider produces ticks, and a counter measures a time-out period in those ticks. Software keeps the system alive by pulsing `kick`. If the period runs out first, the block takes one of three actions, chosen by the mode:

- it flags an interrupt;
- it issues a one-cycle reset request;
- it flags an interrupt first and escalates to a reset request on the following expiry.

One byte-wide register holds the mode and the period. Changes that would weaken the watchdog go through a two-write unlock sequence that must finish within a short window: clearing the reset enable, or picking a different period. A fuse input pins the block to reset-only operation.

Register bit layout, as seen on `wr_data` and `rd_data`:

| Bit | Meaning |
|-----|---------|
| 7 | interrupt flag, read-only |
| 6 | interrupt enable |
| 4 | change window open |
| 3 | reset enable |
| 2:0 | period select `p` |

Bits 5 and 7 ignore writes. Bit 5 reads 0. The period is 2^(BASE_LOG2+p) ticks, and one tick is 2^DIV_LOG2 clock cycles.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `rd_data` is 0x00, `irq` is 0 and `rst_req` is 0. With `fuse_rst_only` high, `rd_data` is 0x08 instead.
- R2: With bit 6 = 1 and bit 3 = 0 (interrupt-only mode), `irq` rises exactly one period after the counter starts, and `rst_req` is never asserted. The counter then restarts at once, so the next expiry comes one period later.
- R3: With bit 3 = 1 and bit 6 = 0 (reset-only mode), `rst_req` is high for one cycle exactly one period after the counter starts. In that same cycle, the register already reads its reset value.
- R4: With bits 6 and 3 both set (combined mode), the first expiry raises `irq`, clears bit 6 in hardware and leaves bit 3 set. The next expiry, one period later, gives the reset pulse.
- R5: While `fuse_rst_only` is high, bit 3 reads 1 and bit 6 reads 0, and no write changes either. Expiry then always produces `rst_req` and never `irq`.
- R6: A write with bits 4 and 3 both set is the unlock write. It opens a window in which bit 4 reads 1 for four cycles. After that the window closes by itself.
- R7: A write with bit 4 = 0, sampled on one of the four clock edges after the unlock edge, loads bit 3 and bits 2:0 from the written data. A write on the fifth edge leaves bits 3 and 2:0 unchanged.
- R8: Outside the window, a write can set bit 3 but not clear it, and it cannot change bits 2:0. Bit 6 takes the written value on the next edge.
- R9: `kick` clears the counter, so the next expiry comes one full period after the kick edge. A kick sampled on the same edge where expiry would occur wins, and no event is produced.
- R10: `irq_ack` clears the flag (bit 7, driven on `irq`). When a new expiry and `irq_ack` fall on the same edge, the flag stays set.
- R11: The period select `p` gives a period of 2^(BASE_LOG2+p) ticks for every `p` from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value (combinational) |
| kick | input | 1 | Watchdog clear; restarts the period |
| fuse_rst_only | input | 1 | Forces reset-only operation |
| irq | output | 1 | Interrupt flag |
| irq_ack | input | 1 | Clears the interrupt flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
There are two same-cycle collisions to cover. The first is a `kick` on the very edge where the counter would expire. The bench provokes it by driving `kick` in the cycle just before the computed expiry edge. It is judged correct if `irq` stays low on that edge and rises one full period later. The second is an `irq_ack` on the edge where a periodic interrupt-mode expiry sets the flag again. It is judged correct if `irq` reads 1 after that edge, and a lone acknowledge later clears it. Random period selects and random kick times make up the rest of the timing checks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_W      = 8;
    localparam int PS_W       = 3;
    localparam int FLAG_BIT   = 7;
    localparam int IE_BIT     = 6;
    localparam int CE_BIT     = 4;
    localparam int RE_BIT     = 3;
    localparam int WIN_CYCLES = 4;
    localparam int WIN_W      = $clog2(WIN_CYCLES + 1);

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_IRQ  = 2'b01,
        MODE_RST  = 2'b10,
        MODE_BOTH = 2'b11
    } wdt_mode_e;

    typedef struct packed {
        logic            flag;
        logic            ie;
        logic            ce;
        logic            re;
        logic [PS_W-1:0] ps;
    } wdt_view_t;

    function automatic wdt_mode_e mode_of(input logic ie, input logic re);
        return wdt_mode_e'({re, ie});
    endfunction

    function automatic logic [REG_W-1:0] pack_view(input wdt_view_t v);
        logic [REG_W-1:0] r;
        r = '0;
        r[FLAG_BIT]   = v.flag;
        r[IE_BIT]     = v.ie;
        r[CE_BIT]     = v.ce;
        r[RE_BIT]     = v.re;
        r[PS_W-1:0]   = v.ps;
        return r;
    endfunction

endpackage

// File: rtl/wdt_tick.sv
module wdt_tick #(
    parameter int DIV_LOG2 = 0
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV_LOG2 == 0) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_divide
            logic [DIV_LOG2-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst) div_q <= '0;
                else     div_q <= div_q + 1'b1;
            end
            assign tick = &div_q;
        end
    endgenerate
endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            run,
    input  logic            kick,
    input  logic [PS_W-1:0] ps,
    output logic            expire
);
    localparam int MAX_PS = (1 << PS_W) - 1;
    localparam int CNT_W  = BASE_LOG2 + MAX_PS;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    assign last_val = {CNT_W{1'b1}} >> (PS_W'(MAX_PS) - ps);
    assign expire   = run && tick && !kick && (cnt_q >= last_val);

    always_ff @(posedge clk) begin
        if (rst || !run || kick) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (expire) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt_q == '0));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             fuse,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             set_flag,
    input  logic             hw_clr_ie,
    input  logic             ack,
    output logic             ie_eff,
    output logic             re_eff,
    output logic [PS_W-1:0]  ps,
    output logic             flag,
    output logic [REG_W-1:0] rd_data
);
    logic             ie_q, re_q, flag_q;
    logic [PS_W-1:0]  ps_q;
    logic [WIN_W-1:0] win_q;
    logic             win_open, unlock, commit;
    wdt_view_t        view;

    assign win_open = (win_q != '0);
    assign unlock   = wr_en && wr_data[CE_BIT] && wr_data[RE_BIT];
    assign commit   = wr_en && !wr_data[CE_BIT] && win_open;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ie_q   <= 1'b0;
            re_q   <= 1'b0;
            ps_q   <= '0;
            flag_q <= 1'b0;
            win_q  <= '0;
        end else begin
            if (unlock)        win_q <= WIN_W'(WIN_CYCLES);
            else if (commit)   win_q <= '0;
            else if (win_open) win_q <= win_q - 1'b1;

            if (commit) begin
                re_q <= wr_data[RE_BIT];
                ps_q <= wr_data[PS_W-1:0];
            end else if (wr_en) begin
                re_q <= re_q | wr_data[RE_BIT];
            end

            if (hw_clr_ie)  ie_q <= 1'b0;
            else if (wr_en) ie_q <= wr_data[IE_BIT];

            if (set_flag) flag_q <= 1'b1;
            else if (ack) flag_q <= 1'b0;
        end
    end

    assign ie_eff = ie_q & ~fuse;
    assign re_eff = re_q | fuse;
    assign ps     = ps_q;
    assign flag   = flag_q;

    always_comb begin
        view.flag = flag_q;
        view.ie   = ie_eff;
        view.ce   = win_open;
        view.re   = re_eff;
        view.ps   = ps_q;
        rd_data   = pack_view(view);
    end

    // R6
    window_open_chk: assert property (@(posedge clk) disable iff (rst)
        (unlock && !soft_rst) |=> win_open);

    // R7
    ps_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (!win_open && !soft_rst) |=> $stable(ps_q));

    // R8
    re_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (re_q && !win_open && !soft_rst) |=> re_q);

    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !set_flag && !soft_rst) |=> !flag_q);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int DIV_LOG2  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             kick,
    input  logic             fuse_rst_only,
    output logic             irq,
    input  logic             irq_ack,
    output logic             rst_req
);
    logic            tick, expire;
    logic            ie_eff, re_eff, flag;
    logic [PS_W-1:0] ps;
    logic            set_flag, hw_clr_ie, fire_rst, rst_req_q;
    wdt_mode_e       mode;

    assign mode      = mode_of(ie_eff, re_eff);
    assign set_flag  = expire && (mode == MODE_IRQ || mode == MODE_BOTH);
    assign hw_clr_ie = expire && (mode == MODE_BOTH);
    assign fire_rst  = expire && (mode == MODE_RST);

    wdt_tick #(.DIV_LOG2(DIV_LOG2)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    wdt_count #(.BASE_LOG2(BASE_LOG2)) u_count (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run    (ie_eff | re_eff),
        .kick   (kick),
        .ps     (ps),
        .expire (expire)
    );

    wdt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (fire_rst),
        .fuse      (fuse_rst_only),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .set_flag  (set_flag),
        .hw_clr_ie (hw_clr_ie),
        .ack       (irq_ack),
        .ie_eff    (ie_eff),
        .re_eff    (re_eff),
        .ps        (ps),
        .flag      (flag),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) rst_req_q <= 1'b0;
        else     rst_req_q <= fire_rst;
    end

    assign rst_req = rst_req_q;
    assign irq     = flag;

    // R3
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R2
    irq_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IRQ) |=> !rst_req);

    // R9
    kick_wins_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> (!rst_req && !$rose(irq)));

    // R5
    fuse_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (fuse_rst_only && $past(fuse_rst_only)) |-> !$rose(irq));
endmodule

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;
    localparam int BASE = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       kick = 1'b0;
    logic       fuse = 1'b0;
    logic       irq;
    logic       irq_ack = 1'b0;
    logic       rst_req;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    wdt_guard #(.BASE_LOG2(BASE), .DIV_LOG2(0)) uut (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .kick          (kick),
        .fuse_rst_only (fuse),
        .irq           (irq),
        .irq_ack       (irq_ack),
        .rst_req       (rst_req)
    );

    function automatic int period(input int p);
        return 1 << (BASE + p);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic f);
        rst = 1'b1;
        fuse = f;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_event(input int n, input bit on_rst, input string req);
        idle(n - 1);
        check(req, on_rst ? int'(rst_req) : int'(irq), 0);
        idle(1);
        check(req, on_rst ? int'(rst_req) : int'(irq), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        idle(3);
        check("R1 reset value", rd_data, 8'h00);
        check("R1 irq idle", irq, 0);
        check("R1 rst_req idle", rst_req, 0);
        rst = 1'b0;

        // R2 interrupt-only period, restart, no reset
        do_reset(1'b0);
        wr(8'h40);
        expect_event(period(0), 1'b0, "R2 first expiry");
        check("R2 flag readback", rd_data, 8'hC0);
        check("R2 no reset", rst_req, 0);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check("R10 ack clears", irq, 0);
        expect_event(period(0) - 1, 1'b0, "R2 restart");
        // R10 set and ack on the same edge
        idle(period(0) - 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check("R10 set beats ack", irq, 1);
        check("R2 still no reset", rst_req, 0);

        // R9 kick on the expiry edge
        do_reset(1'b0);
        wr(8'h40);
        idle(period(0) - 1);
        pulse_kick();
        check("R9 kick wins", irq, 0);
        expect_event(period(0), 1'b0, "R9 period after kick");

        // R6 / R7 qualifying write on the last edge of the window
        do_reset(1'b0);
        wr(8'h18);
        check("R6 window open", rd_data, 8'h18);
        idle(3);
        wr(8'h05);
        check("R7 late-in-window commit", rd_data, 8'h05);

        // R6 / R7 window expiry and rejected write
        do_reset(1'b0);
        wr(8'h18);
        idle(3);
        check("R6 window still open", rd_data[4], 1);
        idle(1);
        check("R6 window closed", rd_data, 8'h08);
        wr(8'h05);
        check("R7 write after window ignored", rd_data, 8'h08);

        // R8 unprotected writes
        do_reset(1'b0);
        wr(8'h08);
        check("R8 set reset enable", rd_data, 8'h08);
        wr(8'h00);
        check("R8 cannot clear reset enable", rd_data, 8'h08);
        wr(8'h47);
        check("R8 ie immediate, ps locked", rd_data, 8'h48);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] d;
            d = 8'($urandom) & 8'hE7;
            do_reset(1'b0);
            wr(d);
            check("R8 random write", rd_data, int'(d & 8'h48));
        end

        // R3 / R11 reset-only after unlock with period select 2
        do_reset(1'b0);
        wr(8'h18);
        wr(8'h0A);
        check("R7 commit loads period", rd_data, 8'h0A);
        pulse_kick();
        expect_event(period(2), 1'b1, "R3 reset at period");
        check("R3 defaults restored", rd_data, 8'h00);
        check("R3 no irq", irq, 0);
        idle(1);
        check("R3 single-cycle pulse", rst_req, 0);

        // R4 combined mode escalation
        do_reset(1'b0);
        wr(8'h48);
        expect_event(period(0), 1'b0, "R4 first expiry irq");
        check("R4 ie cleared by hardware", rd_data, 8'h88);
        check("R4 no reset yet", rst_req, 0);
        expect_event(period(0), 1'b1, "R4 second expiry reset");
        check("R4 defaults after reset", rd_data, 8'h00);

        // R5 fuse forces reset-only
        do_reset(1'b1);
        check("R5 fuse reset value", rd_data, 8'h08);
        wr(8'h40);
        check("R5 ie write blocked", rd_data, 8'h08);
        pulse_kick();
        expect_event(period(0), 1'b1, "R5 fuse gives reset");
        check("R5 fuse no irq", irq, 0);
        wr(8'h18);
        wr(8'h03);
        check("R5 re stays forced", rd_data, 8'h0B);
        fuse = 1'b0;

        // R11 / R9 random period selects and kick times
        for (int i = 0; i < 16; i++) begin
            int p;
            int m;
            p = int'($urandom % 8);
            do_reset(1'b0);
            wr(8'h18);
            wr(8'(8'h40 | p));
            check("R11 period select readback", rd_data, 8'h40 | p);
            pulse_kick();
            m = int'($urandom % (period(p) - 1));
            idle(m);
            check("R9 no expiry before kick", irq, 0);
            pulse_kick();
            expect_event(period(p), 1'b0, "R11 random period");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule